// File: doc/BRIEF.md
# Counting Vectored Interrupt Controller

This block collects 32 level-sensitive interrupt request lines and merges them into two processor-facing outputs: a normal interrupt and a fast interrupt. Each request line passes through a two-flop synchronizer. Its transitions set or clear a recorded level bit. The normal output is active while any recorded level is also enabled for it.

Software works the block through a small synchronous register port with a byte offset, a read/write select and a valid strobe, inside a 4 KiB window. A source is enabled or disabled by writing its index, not a mask. The block also keeps a running count of active enabled sources. That count moves by small increments on every level change and every enable change, so software can read how many sources are waiting without scanning. Another offset returns the lowest waiting index. A wipe command drops every recorded level at once and leaves the enables alone.

The fast interrupt has its own enable mask. That mask has no register path and resets to zero, so the fast output stays idle.

Top module: `cnt_vec_intc`

## Requirements
- R1: A rising edge of a synchronized request input sets that source's recorded level bit, and a falling edge clears it. A change driven on `req_i` just after a clock edge is reflected in the outputs after the third following rising edge.
- R2: A read at offset 0x00 returns the number of sources whose recorded level and normal enable are both set. The count stays correct across level rises, level falls, enable writes, disable writes and wipes.
- R3: A read at offset 0x04 returns the lowest source index whose recorded level and normal enable are both set, or 0 when there is none.
- R4: A write at offset 0x10 sets the normal enable of the source whose index is in `bus_wdata`. Enabling a source that is already enabled changes nothing. An index of 32 or more is ignored.
- R5: A write at offset 0x0C clears the normal enable of the indexed source. Disabling an already disabled source changes nothing, and an index of 32 or more is ignored.
- R6: A write at offset 0x08 clears every recorded level bit and the count, and keeps the enable mask. A request held high across the wipe is not recorded again until it falls and rises again.
- R7: `irq_o` is high exactly while at least one source has its recorded level and normal enable both set. It follows the state with no register stage.
- R8: `fiq_o` is the OR of recorded levels masked by a fast-enable mask that resets to zero and has no write path, so `fiq_o` stays low.
- R9: Read data is registered and appears on `bus_rdata` in the cycle after the read access. In every other cycle it is 0. A write takes effect at the clock edge that samples it.
- R10: An access whose offset is not one of the five above, or whose direction is wrong for its offset, returns 0, changes no state, and raises `bus_err` for exactly one cycle, in the cycle after the access.
- R11: While reset is asserted, all levels, enables, the count, `bus_rdata`, `bus_err`, `irq_o` and `fiq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 32 | Level-sensitive request lines, asynchronous |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data, a source index for enable and disable |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a bad access |
| irq_o | output | 1 | Combined normal interrupt |
| fiq_o | output | 1 | Combined fast interrupt |

## Verification
A request change reaches the recorded levels and `irq_o` after three rising edges: two synchronizer flops and one edge-detect stage. The bench drives requests at a falling edge and samples them at the third falling edge after that. Register reads return data one edge after the strobe, and writes update state at that same edge. Each bus task therefore samples `bus_rdata`, `bus_err` and `irq_o` at the falling edge that directly follows the access. The wipe test and the error test also sample on later cycles, to show that nothing reappears and that the error pulse lasts only one cycle.

// File: rtl/cnt_vec_intc.sv
module cnt_vec_intc #(
  parameter int NSRC = 32,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_offset,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_err,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CW   = $clog2(NSRC + 1);
  localparam logic [AW-1:0] OFS_COUNT  = AW'(12'h000);
  localparam logic [AW-1:0] OFS_LOWEST = AW'(12'h004);
  localparam logic [AW-1:0] OFS_WIPE   = AW'(12'h008);
  localparam logic [AW-1:0] OFS_DIS    = AW'(12'h00C);
  localparam logic [AW-1:0] OFS_EN     = AW'(12'h010);

  logic [NSRC-1:0] sync1, sync2, prev;
  logic [NSRC-1:0] lvl, en, fiq_en;
  logic [CW-1:0]   cnt;

  logic wr, rd, do_wipe, do_en, do_dis, hit, idx_ok;
  logic [IDXW-1:0] idx;
  assign wr      = bus_valid &  bus_write;
  assign rd      = bus_valid & ~bus_write;
  assign do_wipe = wr && bus_offset == OFS_WIPE;
  assign do_dis  = wr && bus_offset == OFS_DIS;
  assign do_en   = wr && bus_offset == OFS_EN;
  assign hit     = (rd && (bus_offset == OFS_COUNT || bus_offset == OFS_LOWEST))
                 || do_wipe || do_dis || do_en;
  assign idx_ok  = bus_wdata < DW'(NSRC);
  assign idx     = bus_wdata[IDXW-1:0];

  logic [NSRC-1:0] rise, fall, lvl_n, en_n, act;
  assign rise  = sync2 & ~prev;
  assign fall  = ~sync2 & prev;
  assign lvl_n = do_wipe ? '0 : ((lvl | rise) & ~fall);
  assign act   = lvl & en;

  always_comb begin
    en_n = en;
    if (do_en && idx_ok)  en_n[idx] = 1'b1;
    if (do_dis && idx_ok) en_n[idx] = 1'b0;
  end

  function automatic logic [CW-1:0] popc(input logic [NSRC-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < NSRC; i++) s = s + CW'(v[i]);
    return s;
  endfunction

  logic [CW-1:0] up, down, cnt_n;
  logic en_set, en_clr;
  assign up     = popc(rise & en);
  assign down   = popc(fall & lvl & en);
  assign en_set = do_en  && idx_ok && !en[idx] && lvl_n[idx];
  assign en_clr = do_dis && idx_ok &&  en[idx] && lvl_n[idx];
  assign cnt_n  = do_wipe ? '0 : (cnt + up + CW'(en_set) - down - CW'(en_clr));

  logic [IDXW-1:0] low_idx;
  always_comb begin
    low_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (act[i]) low_idx = IDXW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; prev <= '0;
      lvl <= '0; en <= '0; fiq_en <= '0; cnt <= '0;
      bus_rdata <= '0; bus_err <= 1'b0;
    end else begin
      sync1  <= req_i;
      sync2  <= sync1;
      prev   <= sync2;
      lvl    <= lvl_n;
      en     <= en_n;
      fiq_en <= '0;
      cnt    <= cnt_n;
      bus_err <= bus_valid && !hit;
      if (rd && bus_offset == OFS_COUNT)
        bus_rdata <= DW'(cnt);
      else if (rd && bus_offset == OFS_LOWEST)
        bus_rdata <= DW'(low_idx);
      else
        bus_rdata <= '0;
    end
  end

  assign irq_o = |act;
  assign fiq_o = |(lvl & fiq_en);

  p_count_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lvl & en) == int'(cnt));
  p_irq_matches_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (cnt != '0));
  p_fiq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) !fiq_o);
  p_wipe_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_wipe |=> (lvl == '0 && cnt == '0 && $stable(en)));
  p_enable_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_en && idx_ok) |=> en[$past(idx)]);
  p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_dis && idx_ok) |=> !en[$past(idx)]);
  p_level_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise == '0 && fall == '0 && !do_wipe) |=> $stable(lvl));
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> bus_rdata == '0);
  p_err_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rdata == '0);
  p_lowest_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_offset == OFS_LOWEST && act == '0) |=> bus_rdata == '0);
endmodule

// File: tb/tb_cnt_vec_intc.sv
`timescale 1ns/1ps
module tb_cnt_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_i = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_offset = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, irq_o, fiq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cnt_vec_intc dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_offset(bus_offset),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // {req, enable mask, expected count, expected lowest index}
  localparam logic [79:0] VEC [8] = '{
    {32'h0000_0001, 32'hFFFF_FFFF, 8'd1,  8'd0},
    {32'h8000_0000, 32'hFFFF_FFFF, 8'd1,  8'd31},
    {32'hF000_000F, 32'h0000_00F0, 8'd0,  8'd0},
    {32'h0000_FF00, 32'h0000_0F00, 8'd4,  8'd8},
    {32'hFFFF_FFFF, 32'hAAAA_AAAA, 8'd16, 8'd1},
    {32'h5555_5555, 32'hAAAA_AAAA, 8'd0,  8'd0},
    {32'h0001_0100, 32'hFFFF_0000, 8'd1,  8'd16},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd32, 8'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [11:0] off, output logic [31:0] d, output logic e);
    bus_valid = 1'b1; bus_write = 1'b0; bus_offset = off;
    @(negedge clk);
    d = bus_rdata; e = bus_err;
    bus_valid = 1'b0;
  endtask

  task automatic bus_wr(input logic [11:0] off, input logic [31:0] v, output logic e);
    bus_valid = 1'b1; bus_write = 1'b1; bus_offset = off; bus_wdata = v;
    @(negedge clk);
    e = bus_err;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic set_mask(input logic [31:0] m);
    logic e;
    for (int i = 0; i < 32; i++) bus_wr(m[i] ? 12'h010 : 12'h00C, i, e);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic e;
    step(3);
    chk("R11 irq in reset", {31'b0, irq_o}, 0);
    chk("R11 fiq in reset", {31'b0, fiq_o}, 0);
    chk("R11 rdata in reset", bus_rdata, 0);
    chk("R11 err in reset", {31'b0, bus_err}, 0);
    rst_n = 1'b1;
    step(1);
    bus_rd(12'h000, d, e); chk("R11 count after reset", d, 0);
    step(1);
    chk("R9 rdata idle", bus_rdata, 0);

    for (int v = 0; v < 8; v++) begin
      set_mask(VEC[v][47:16]);
      req_i = VEC[v][79:48];
      step(3);
      chk($sformatf("R7 irq vec %0d", v), {31'b0, irq_o}, {31'b0, VEC[v][15:8] != 0});
      chk($sformatf("R8 fiq vec %0d", v), {31'b0, fiq_o}, 0);
      bus_rd(12'h000, d, e); chk($sformatf("R2 count vec %0d", v), d, {24'b0, VEC[v][15:8]});
      bus_rd(12'h004, d, e); chk($sformatf("R3 lowest vec %0d", v), d, {24'b0, VEC[v][7:0]});
    end

    req_i = '0;
    set_mask(32'h0);
    step(3);
    bus_wr(12'h008, 0, e);

    req_i[5] = 1'b1;
    step(3);
    bus_rd(12'h000, d, e); chk("R1 disabled rise not counted", d, 0);
    chk("R7 irq low while disabled", {31'b0, irq_o}, 0);
    bus_wr(12'h010, 5, e);
    chk("R4 enable active source raises irq", {31'b0, irq_o}, 1);
    bus_rd(12'h000, d, e); chk("R4 enable increments count", d, 1);
    bus_wr(12'h010, 5, e);
    bus_rd(12'h000, d, e); chk("R4 repeated enable no change", d, 1);
    bus_rd(12'h004, d, e); chk("R3 lowest is 5", d, 5);
    bus_wr(12'h00C, 5, e);
    chk("R5 disable drops irq", {31'b0, irq_o}, 0);
    bus_rd(12'h000, d, e); chk("R5 disable decrements", d, 0);
    bus_wr(12'h00C, 5, e);
    bus_rd(12'h000, d, e); chk("R5 repeated disable no change", d, 0);
    bus_wr(12'h010, 5, e);
    req_i[5] = 1'b0;
    step(3);
    bus_rd(12'h000, d, e); chk("R1 fall decrements", d, 0);

    req_i[0] = 1'b1;
    step(3);
    bus_wr(12'h010, 32, e);
    bus_rd(12'h000, d, e); chk("R4 index 32 ignored", d, 0);
    bus_wr(12'h010, 0, e);
    bus_rd(12'h000, d, e); chk("R4 enable source 0", d, 1);
    bus_wr(12'h00C, 32, e);
    bus_rd(12'h000, d, e); chk("R5 index 32 ignored", d, 1);

    bus_wr(12'h008, 0, e);
    chk("R6 wipe drops irq", {31'b0, irq_o}, 0);
    bus_rd(12'h000, d, e); chk("R6 wipe clears count", d, 0);
    step(5);
    bus_rd(12'h000, d, e); chk("R6 held input not re-recorded", d, 0);
    req_i[0] = 1'b0;
    step(3);
    req_i[0] = 1'b1;
    step(3);
    bus_rd(12'h000, d, e); chk("R6 enable kept after wipe", d, 1);
    chk("R7 irq after re-rise", {31'b0, irq_o}, 1);

    bus_rd(12'h014, d, e);
    chk("R10 bad read data", d, 0);
    chk("R10 bad read err", {31'b0, e}, 1);
    step(1);
    chk("R10 err one cycle", {31'b0, bus_err}, 0);
    bus_rd(12'h008, d, e); chk("R10 read of write-only err", {31'b0, e}, 1);
    bus_wr(12'h000, 0, e); chk("R10 write to read-only err", {31'b0, e}, 1);
    bus_wr(12'h020, 0, e); chk("R10 bad write err", {31'b0, e}, 1);
    bus_rd(12'h000, d, e);
    chk("R10 bad write left count", d, 1);
    chk("R10 good read no err", {31'b0, e}, 0);
    bus_wr(12'h00C, 0, e); chk("R9 good write no err", {31'b0, e}, 0);
    chk("R9 write applied at sampling edge", {31'b0, irq_o}, 0);
    chk("R8 fiq stays low", {31'b0, fiq_o}, 0);

    summary();
  end
endmodule